// File: doc/BRIEF.md
# Read-after-write hazard interlock

This unit sits beside the decode stage of an in-order pipeline and decides when a freshly decoded instruction may go on to read the register file and advance the program counter. Decode raises a check request with the incoming instruction's kind and its two source register numbers. The unit compares those numbers with the destination registers of the instructions still in flight. It grants the request only when no earlier instruction still owes a write to one of those registers. Until then decode stalls, so the operands it reads are always current. There are no bypass paths.

Each in-flight position has its own tracking slot: execute-to-memory, memory-to-writeback and the pending register-write request. An issue pulse from the upstream stage fills a slot. A retire pulse, sent when the downstream stage accepts the instruction, empties it. A slot therefore stays visible for as long as its instruction is held, including a load stalled on data memory. The request and grant follow a four-phase handshake. The grant is a register output.

Top module: `hz_interlock`

## Requirements
- R1: While rst_ni is low, chk_ack_o is 0 and every slot is empty. An empty slot never stalls a request.
- R2: A slot holding a register-op (kind 2'b00) or load (kind 2'b01) conflicts with a request of kind register-op, store (2'b10) or branch (2'b11) when its destination equals chk_src_a_i or chk_src_b_i. While any conflict exists, chk_ack_o stays 0.
- R3: For a load request, only chk_src_a_i is compared. A match on chk_src_b_i has no effect on the grant.
- R4: A slot holding a store or a branch never conflicts, whatever its destination field holds.
- R5: Slot k (bit k of slot_issue_i/slot_retire_i; its kind at bits [2k+1:2k] and its destination at [k*RW +: RW]; slot 0 is execute, 1 is memory, 2 is writeback) becomes pending at the edge where its issue bit is high. It stays pending until an edge where its retire bit is high and its issue bit is low. Issue and retire together replace the slot's contents, and the slot stays pending.
- R6: chk_ack_o rises at the first rising edge where chk_req_i is high and no conflict exists. A conflict removed by a retire at edge e no longer blocks at edge e+1. chk_ack_o never rises without a request.
- R7: Once high, chk_ack_o stays high while chk_req_i stays high, even if a conflicting writer is issued. It falls at the first edge where chk_req_i is low.
- R8: Register 0 is compared like any other register number.
- R9: All slots are checked together. The request stays stalled until every conflicting slot has retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_req_i | input | 1 | Check request from decode |
| chk_kind_i | input | 2 | Incoming instruction kind |
| chk_src_a_i | input | RW | First source register |
| chk_src_b_i | input | RW | Second source register |
| chk_ack_o | output | 1 | Registered grant |
| slot_issue_i | input | NSLOT | Per-slot fill pulse |
| slot_retire_i | input | NSLOT | Per-slot empty pulse |
| slot_kind_i | input | 2*NSLOT | Kind captured on fill |
| slot_dst_i | input | RW*NSLOT | Destination captured on fill |

## Verification
If a slot's pending flag is lost or set wrongly, the fault shows at chk_ack_o. A lost flag lets a grant through one cycle after a conflicting request is raised. A flag that is stuck or set wrongly holds the grant low long after the matching retire. A mis-captured destination or kind shows the same way on the next request that names that register. A handshake state fault shows within one edge of a change in chk_req_i, as a grant that is held, dropped or raised on the wrong edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    K_REGOP  = 2'b00,
    K_LOAD   = 2'b01,
    K_STORE  = 2'b10,
    K_BRANCH = 2'b11
  } op_kind_e;

  function automatic logic kind_writes(op_kind_e k);
    return (k == K_REGOP) || (k == K_LOAD);
  endfunction

  // loads consume only source a
  function automatic logic kind_uses_b(op_kind_e k);
    return k != K_LOAD;
  endfunction
endpackage

// File: rtl/hz_slot.sv
module hz_slot
  import hz_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          retire_i,
  input  logic [1:0]    kind_i,
  input  logic [RW-1:0] dst_i,
  output logic          busy_o,
  output logic          writes_o,
  output logic [RW-1:0] dst_o
);
  op_kind_e      kind_q;
  logic          busy_q;
  logic [RW-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= K_STORE;
      dst_q  <= '0;
    end else if (issue_i) begin
      busy_q <= 1'b1;
      kind_q <= op_kind_e'(kind_i);
      dst_q  <= dst_i;
    end else if (retire_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign writes_o = busy_q && kind_writes(kind_q);
  assign dst_o    = dst_q;
endmodule

// File: rtl/hz_match.sv
module hz_match #(
  parameter int RW = 5
) (
  input  logic          writes_i,
  input  logic [RW-1:0] dst_i,
  input  logic [RW-1:0] src_a_i,
  input  logic [RW-1:0] src_b_i,
  input  logic          use_b_i,
  output logic          hit_o
);
  logic hit_a, hit_b;
  assign hit_a = dst_i == src_a_i;
  assign hit_b = use_b_i && (dst_i == src_b_i);
  assign hit_o = writes_i && (hit_a || hit_b);
endmodule

// File: rtl/hz_handshake.sv
module hz_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clear_i,
  output logic ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ack_q <= 1'b0;
    else if (ack_q)  ack_q <= req_i;
    else             ack_q <= req_i && clear_i;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NSLOT = 3,
  parameter int RW    = $clog2(NREG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chk_req_i,
  input  logic [1:0]          chk_kind_i,
  input  logic [RW-1:0]       chk_src_a_i,
  input  logic [RW-1:0]       chk_src_b_i,
  output logic                chk_ack_o,
  input  logic [NSLOT-1:0]    slot_issue_i,
  input  logic [NSLOT-1:0]    slot_retire_i,
  input  logic [2*NSLOT-1:0]  slot_kind_i,
  input  logic [RW*NSLOT-1:0] slot_dst_i
);
  logic [NSLOT-1:0] slot_busy;
  logic [NSLOT-1:0] slot_writes;
  logic [NSLOT-1:0] slot_hit;
  logic             use_b;
  logic             conflict;

  assign use_b = kind_uses_b(op_kind_e'(chk_kind_i));

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [RW-1:0] dst;

    hz_slot #(.RW(RW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .issue_i  (slot_issue_i[k]),
      .retire_i (slot_retire_i[k]),
      .kind_i   (slot_kind_i[2*k +: 2]),
      .dst_i    (slot_dst_i[RW*k +: RW]),
      .busy_o   (slot_busy[k]),
      .writes_o (slot_writes[k]),
      .dst_o    (dst)
    );

    hz_match #(.RW(RW)) u_match (
      .writes_i (slot_writes[k]),
      .dst_i    (dst),
      .src_a_i  (chk_src_a_i),
      .src_b_i  (chk_src_b_i),
      .use_b_i  (use_b),
      .hit_o    (slot_hit[k])
    );
  end

  assign conflict = |slot_hit;

  hz_handshake u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (chk_req_i),
    .clear_i (!conflict),
    .ack_o   (chk_ack_o)
  );
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int NSLOT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chk_req_i,
  input logic             chk_ack_o,
  input logic [NSLOT-1:0] slot_issue_i,
  input logic [NSLOT-1:0] slot_retire_i,
  input logic [NSLOT-1:0] slot_busy,
  input logic [NSLOT-1:0] slot_writes,
  input logic [NSLOT-1:0] slot_hit,
  input logic             conflict
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_idle: assert (!chk_ack_o && slot_busy == '0);
    end
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ack_o && chk_req_i) |=> chk_ack_o);

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ack_o && !chk_req_i) |=> !chk_ack_o);

  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_ack_o && !chk_req_i) |=> !chk_ack_o);

  a_r6_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_ack_o && chk_req_i && !conflict) |=> chk_ack_o);

  a_r2_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_ack_o && conflict) |=> !chk_ack_o);

  for (genvar k = 0; k < NSLOT; k++) begin : g_chk
    a_r5_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_issue_i[k] |=> slot_busy[k]);

    a_r5_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_retire_i[k] && !slot_issue_i[k]) |=> !slot_busy[k]);

    a_r4_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_writes[k] |-> !slot_hit[k]);
  end
endmodule

bind hz_interlock hz_interlock_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chk_req_i     (chk_req_i),
  .chk_ack_o     (chk_ack_o),
  .slot_issue_i  (slot_issue_i),
  .slot_retire_i (slot_retire_i),
  .slot_busy     (slot_busy),
  .slot_writes   (slot_writes),
  .slot_hit      (slot_hit),
  .conflict      (conflict)
);

// File: tb/hz_interlock_tb.sv
module hz_interlock_tb;
  localparam int NS = 3;
  localparam int RW = 5;
  localparam logic [1:0] REGOP = 2'b00, LOAD = 2'b01, STORE = 2'b10, BRANCH = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req = 1'b0;
  logic [1:0] kind = REGOP;
  logic [RW-1:0] src_a = '0, src_b = '0;
  logic ack;
  logic [NS-1:0] iss = '0, ret = '0;
  logic [2*NS-1:0] skind = '0;
  logic [RW*NS-1:0] sdst = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hz_interlock #(.NREG(32), .NSLOT(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chk_req_i(req), .chk_kind_i(kind),
    .chk_src_a_i(src_a), .chk_src_b_i(src_b), .chk_ack_o(ack),
    .slot_issue_i(iss), .slot_retire_i(ret), .slot_kind_i(skind), .slot_dst_i(sdst)
  );

  // requirement model
  logic [NS-1:0] m_busy;
  logic [1:0]    m_kind [NS];
  logic [RW-1:0] m_dst  [NS];
  logic          m_ack;

  function automatic logic exp_conflict();
    logic c = 1'b0;
    for (int k = 0; k < NS; k++)
      if (m_busy[k] && (m_kind[k] == REGOP || m_kind[k] == LOAD) &&
          (m_dst[k] == src_a || (kind != LOAD && m_dst[k] == src_b)))
        c = 1'b1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= '0;
      m_ack  <= 1'b0;
      for (int k = 0; k < NS; k++) begin
        m_kind[k] <= STORE;
        m_dst[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < NS; k++) begin
        if (iss[k]) begin
          m_busy[k] <= 1'b1;
          m_kind[k] <= skind[2*k +: 2];
          m_dst[k]  <= sdst[RW*k +: RW];
        end else if (ret[k]) m_busy[k] <= 1'b0;
      end
      m_ack <= m_ack ? req : (req && !exp_conflict());
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: ack got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) chk("R6/R7 model", ack, m_ack);
  end

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [NS-1:0] im, logic [NS-1:0] rm, logic [1:0] kd, logic [RW-1:0] d);
    for (int k = 0; k < NS; k++) begin
      if (im[k]) begin
        skind[2*k +: 2]  = kd;
        sdst[RW*k +: RW] = d;
      end
    end
    iss = im;
    ret = rm;
    nclk(1);
    iss = '0;
    ret = '0;
  endtask

  task automatic req_on(logic [1:0] kd, logic [RW-1:0] a, logic [RW-1:0] b);
    kind = kd; src_a = a; src_b = b; req = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    #2 rst_n = 1'b0;
    nclk(2);
    chk("R1 reset", ack, 1'b0);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 empty slots", ack, 1'b0);

    req_on(REGOP, 1, 2); nclk(1);
    chk("R6 grant", ack, 1'b1);
    req = 0; nclk(1);
    chk("R7 release", ack, 1'b0);

    pulse(3'b001, 3'b000, REGOP, 5);
    req_on(REGOP, 3, 5); nclk(3);
    chk("R2 stall on b", ack, 1'b0);
    pulse(3'b000, 3'b001, REGOP, 0);
    chk("R5 retire edge still blocks", ack, 1'b0);
    nclk(1);
    chk("R5 grant after retire", ack, 1'b1);
    req = 0; nclk(1);

    pulse(3'b010, 3'b000, LOAD, 7);
    req_on(LOAD, 2, 7); nclk(1);
    chk("R3 load ignores b", ack, 1'b1);
    req = 0; nclk(1);
    req_on(LOAD, 7, 0); nclk(2);
    chk("R3 load stalls on a", ack, 1'b0);
    req = 0;
    pulse(3'b000, 3'b010, REGOP, 0);
    nclk(1);

    pulse(3'b100, 3'b000, STORE, 4);
    pulse(3'b001, 3'b000, BRANCH, 4);
    req_on(REGOP, 4, 4); nclk(1);
    chk("R4 store/branch in flight", ack, 1'b1);
    req = 0; nclk(1);
    pulse(3'b000, 3'b101, REGOP, 0);

    pulse(3'b100, 3'b000, REGOP, 0);
    req_on(STORE, 1, 0); nclk(2);
    chk("R8 register 0 stalls", ack, 1'b0);
    pulse(3'b000, 3'b100, REGOP, 0);
    nclk(1);
    chk("R8 register 0 released", ack, 1'b1);
    req = 0; nclk(1);

    pulse(3'b001, 3'b000, REGOP, 1);
    pulse(3'b010, 3'b000, LOAD, 2);
    pulse(3'b100, 3'b000, REGOP, 3);
    req_on(BRANCH, 2, 3); nclk(1);
    chk("R9 two conflicts", ack, 1'b0);
    pulse(3'b000, 3'b010, REGOP, 0);
    nclk(1);
    chk("R9 one conflict left", ack, 1'b0);
    pulse(3'b000, 3'b100, REGOP, 0);
    nclk(1);
    chk("R9 all retired", ack, 1'b1);

    pulse(3'b010, 3'b000, REGOP, 2);
    chk("R7 held despite new writer", ack, 1'b1);
    req = 0; nclk(1);
    chk("R7 drop", ack, 1'b0);

    pulse(3'b000, 3'b010, REGOP, 0);
    pulse(3'b001, 3'b001, REGOP, 6);
    req_on(REGOP, 1, 9); nclk(1);
    chk("R5 old contents replaced", ack, 1'b1);
    req = 0; nclk(1);
    req_on(REGOP, 9, 6); nclk(2);
    chk("R5 handoff keeps pending", ack, 1'b0);
    req = 0;
    pulse(3'b000, 3'b001, REGOP, 0);
    nclk(1);

    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < NS; k++) begin
        iss[k] = ($urandom % 4) == 0;
        ret[k] = ($urandom % 4) == 0;
        if (iss[k]) begin
          skind[2*k +: 2]  = 2'($urandom % 4);
          sdst[RW*k +: RW] = RW'($urandom % 4);
        end
      end
      if (!req && !ack && ($urandom % 3) == 0)
        req_on(2'($urandom % 4), RW'($urandom % 4), RW'($urandom % 4));
      else if (req && ack && ($urandom % 2) == 0)
        req = 0;
      else if (req && !ack && ($urandom % 16) == 0)
        req = 0;
      nclk(1);
    end
    iss = '0; ret = '0; req = 0;
    nclk(2);
    done = 1;
    summary();
  end
endmodule